// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block supports atomic read-modify-write sequences built from a load-linked operation and a store-conditional operation on a memory shared by several requesters (two by default). Every cycle, each requester may present one operation: a plain load, a plain store, a load-linked or a store-conditional. The monitor decides in that same cycle which writes reach memory. It reports whether each store-conditional succeeded on the following clock edge, as a 1 or 0 value meant for the issuing requester's destination register.

Each requester owns one reservation slot holding a word address. A load-linked fills the slot. Any write that reaches memory at that word empties it, and so does the requester's own store-conditional. A store-conditional may write only while its issuer still holds a matching reservation, so no other write can land on the word between the linked read and a successful conditional write. The memory array itself and the pipeline around the block are outside it. There is no ready signal in either direction. One operation per requester is taken every cycle, and the responses cannot be stalled.

Top module: `rsv_monitor`

## Requirements
- R1: The operation code on `op_kind` is 2 bits per requester: 00 plain load, 01 plain store, 10 load-linked, 11 store-conditional. A valid load-linked records a reservation for its issuer on the word address `op_addr[31:2]`. The byte offset bits [1:0] play no part in any address comparison.
- R2: A valid plain store raises `wr_commit` for its requester in the same cycle, always. A plain load or a load-linked never raises `wr_commit`, and a plain load leaves every reservation unchanged.
- R3: A valid store-conditional raises `wr_commit` in the same cycle only if its issuer holds a reservation on the same word and R7 does not block it. A store-conditional to a word other than the reserved one, or with no reservation held, does not commit.
- R4: A store-conditional always clears its issuer's reservation, whether it succeeds or fails.
- R5: One cycle after a valid store-conditional, `sc_rsp_valid` of that requester is 1 and `sc_rsp_ok` is 1 for success or 0 for failure. After any other cycle, `sc_rsp_valid` is 0.
- R6: Any committed write to a reserved word clears that reservation. This covers a store or a store-conditional from any requester, including the holder's own plain store. Writes to other words leave the reservation intact.
- R7: Within one cycle, writes are ordered by requester index, lowest first. A store-conditional fails if a lower-indexed requester commits a write to the same word in that cycle. When two store-conditionals hit one word together, requester 0 wins.
- R8: A load-linked issued in the same cycle as another requester's committed write to that word leaves its issuer with no reservation.
- R9: A new load-linked replaces the issuer's previous reservation.
- R10: Reset empties all reservations and clears the responses. A store-conditional issued before any load-linked fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | NUM_REQ | One operation presented by requester i this cycle |
| op_kind | input | 2*NUM_REQ | Operation code per requester, bits [2i+1:2i] |
| op_addr | input | ADDR_W*NUM_REQ | Byte address per requester, bits [ADDR_W*i +: ADDR_W] |
| wr_commit | output | NUM_REQ | Write of requester i may update memory this cycle |
| sc_rsp_valid | output | NUM_REQ | Store-conditional status of requester i is present |
| sc_rsp_ok | output | NUM_REQ | Status value: 1 success, 0 failure |

## Verification
`wr_commit` is combinational and is due in the same cycle as the operation. Reservation changes take effect at the next rising edge. The status pair appears one rising edge after the store-conditional and is held for a full cycle. The bench drives operations on the falling edge and checks `wr_commit` 1 ns later, before the next rising edge. It checks the status from the previous cycle at the following falling edge, before it drives anything new. Directed sequences target offset-insensitive matching, same-cycle collisions and the ordering of writes against load-linked operations. A long random run over a small pool of colliding addresses is then compared against a bench reservation model.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } op_kind_e;
endpackage

// File: rtl/rsv_slot.sv
// One reservation register per requester, with snooping of committed writes.
module rsv_slot #(
  parameter int NUM_REQ = 2,
  parameter int WORD_W  = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_set,
  input  logic               link_kill,
  input  logic               cond_issue,
  input  logic [WORD_W-1:0]  link_word,
  input  logic [NUM_REQ-1:0] commit_i,
  input  logic [WORD_W-1:0]  word_i [NUM_REQ],
  output logic               held,
  output logic [WORD_W-1:0]  held_word
);
  logic snoop_hit;

  always_comb begin
    snoop_hit = 1'b0;
    for (int j = 0; j < NUM_REQ; j++) begin
      if (commit_i[j] && (word_i[j] == held_word)) snoop_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_word <= '0;
    end else if (link_set) begin
      held      <= !link_kill;
      held_word <= link_word;
    end else if (cond_issue) begin
      held <= 1'b0;
    end else if (snoop_hit && held) begin
      held <= 1'b0;
    end
  end

  assert_link_records_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (link_set && !link_kill) |=> (held && held_word == $past(link_word)));
  assert_cond_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_issue && !link_set) |=> !held);
  assert_snoop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && !link_set) |=> !held);
  assert_link_killed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_set && link_kill) |=> !held);
endmodule

// File: rtl/sc_commit.sv
// Same-cycle write decision: ordered by requester index, lowest first.
module sc_commit
  import rsv_pkg::*;
#(
  parameter int NUM_REQ = 2,
  parameter int WORD_W  = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_REQ-1:0]   op_valid,
  input  logic [2*NUM_REQ-1:0] op_kind,
  input  logic [WORD_W-1:0]    word_i [NUM_REQ],
  input  logic [NUM_REQ-1:0]   held,
  input  logic [WORD_W-1:0]    held_word [NUM_REQ],
  output logic [NUM_REQ-1:0]   commit,
  output logic [NUM_REQ-1:0]   cond_ok,
  output logic [NUM_REQ-1:0]   link_kill
);
  always_comb begin
    logic [NUM_REQ-1:0] cm;
    logic               blocked;
    op_kind_e           k;
    cm = '0;
    cond_ok = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      k = op_kind_e'(op_kind[2*i +: 2]);
      blocked = 1'b0;
      for (int j = 0; j < NUM_REQ; j++) begin
        if ((j < i) && cm[j] && (word_i[j] == word_i[i])) blocked = 1'b1;
      end
      cond_ok[i] = op_valid[i] && (k == OP_COND) && held[i] &&
                   (held_word[i] == word_i[i]) && !blocked;
      cm[i] = (op_valid[i] && (k == OP_STORE)) || cond_ok[i];
    end
    commit = cm;
    link_kill = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      for (int j = 0; j < NUM_REQ; j++) begin
        if ((j != i) && cm[j] && (word_i[j] == word_i[i])) link_kill[i] = 1'b1;
      end
    end
  end

  for (genvar a = 0; a < NUM_REQ; a++) begin : g_chk
    assert_store_commits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid[a] && op_kind[2*a +: 2] == 2'b01) |-> commit[a]);
    for (genvar b = a + 1; b < NUM_REQ; b++) begin : g_pair
      assert_single_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cond_ok[a] && cond_ok[b] && (word_i[a] == word_i[b])));
    end
  end
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int NUM_REQ  = 2,
  parameter int ADDR_W   = 32,
  parameter int WORD_LSB = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REQ-1:0]        op_valid,
  input  logic [2*NUM_REQ-1:0]      op_kind,
  input  logic [ADDR_W*NUM_REQ-1:0] op_addr,
  output logic [NUM_REQ-1:0]        wr_commit,
  output logic [NUM_REQ-1:0]        sc_rsp_valid,
  output logic [NUM_REQ-1:0]        sc_rsp_ok
);
  localparam int WORD_W = ADDR_W - WORD_LSB;

  logic [WORD_W-1:0]  word_v [NUM_REQ];
  logic [WORD_W-1:0]  held_word [NUM_REQ];
  logic [NUM_REQ-1:0] held;
  logic [NUM_REQ-1:0] is_link;
  logic [NUM_REQ-1:0] is_cond;
  logic [NUM_REQ-1:0] cond_ok;
  logic [NUM_REQ-1:0] link_kill;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    assign word_v[i]  = op_addr[ADDR_W*i + WORD_LSB +: WORD_W];
    assign is_link[i] = op_valid[i] && (op_kind_e'(op_kind[2*i +: 2]) == OP_LINK);
    assign is_cond[i] = op_valid[i] && (op_kind_e'(op_kind[2*i +: 2]) == OP_COND);

    rsv_slot #(.NUM_REQ(NUM_REQ), .WORD_W(WORD_W)) slot_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .link_set   (is_link[i]),
      .link_kill  (link_kill[i]),
      .cond_issue (is_cond[i]),
      .link_word  (word_v[i]),
      .commit_i   (wr_commit),
      .word_i     (word_v),
      .held       (held[i]),
      .held_word  (held_word[i])
    );

    assert_rsp_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
      is_cond[i] |=> sc_rsp_valid[i]);
    assert_rsp_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !is_cond[i] |=> (!sc_rsp_valid[i] && !sc_rsp_ok[i]));
    assert_ok_had_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sc_rsp_ok[i] |-> $past(wr_commit[i]));
  end

  sc_commit #(.NUM_REQ(NUM_REQ), .WORD_W(WORD_W)) commit_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .word_i    (word_v),
    .held      (held),
    .held_word (held_word),
    .commit    (wr_commit),
    .cond_ok   (cond_ok),
    .link_kill (link_kill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_rsp_valid <= '0;
      sc_rsp_ok    <= '0;
    end else begin
      sc_rsp_valid <= is_cond;
      sc_rsp_ok    <= cond_ok;
    end
  end
endmodule

// File: tb/rsv_monitor_tb_top.sv
module rsv_monitor_tb_top;
  localparam int NR = 2;
  localparam int AW = 32;
  localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_LL = 2'b10, K_SC = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NR-1:0]    op_valid = '0;
  logic [2*NR-1:0]  op_kind = '0;
  logic [AW*NR-1:0] op_addr = '0;
  logic [NR-1:0]    wr_commit, sc_rsp_valid, sc_rsp_ok;

  always #4 clk = ~clk;

  rsv_monitor #(.NUM_REQ(NR), .ADDR_W(AW), .WORD_LSB(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .wr_commit(wr_commit), .sc_rsp_valid(sc_rsp_valid),
    .sc_rsp_ok(sc_rsp_ok)
  );

  int checks = 0;
  int failures = 0;
  bit         m_held [NR];
  logic [29:0] m_word [NR];
  bit         e_rv [NR];
  bit         e_ok [NR];

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(bit v0, logic [1:0] k0, logic [31:0] a0,
                       bit v1, logic [1:0] k1, logic [31:0] a1);
    bit          v [NR];
    logic [1:0]  k [NR];
    logic [29:0] w [NR];
    bit          cm [NR];
    bit          blk, kill, hit;
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      chk($sformatf("R5 rsp_valid[%0d]", i), sc_rsp_valid[i], e_rv[i]);
      chk($sformatf("R5 rsp_ok[%0d]", i), sc_rsp_ok[i], e_ok[i]);
    end
    v[0] = v0; k[0] = k0; w[0] = a0[31:2];
    v[1] = v1; k[1] = k1; w[1] = a1[31:2];
    op_valid = {v1, v0};
    op_kind  = {k1, k0};
    op_addr  = {a1, a0};
    #1;
    for (int i = 0; i < NR; i++) begin
      blk = 1'b0;
      for (int j = 0; j < i; j++) if (cm[j] && w[j] == w[i]) blk = 1'b1;
      cm[i] = v[i] && (k[i] == K_ST ||
              (k[i] == K_SC && m_held[i] && m_word[i] == w[i] && !blk));
      chk($sformatf("%s wr_commit[%0d]", (k[i] == K_SC) ? "R3/R7" : "R2", i),
          wr_commit[i], cm[i]);
      e_rv[i] = v[i] && k[i] == K_SC;
      e_ok[i] = e_rv[i] && cm[i];
    end
    for (int i = 0; i < NR; i++) begin
      if (v[i] && k[i] == K_LL) begin
        kill = 1'b0;
        for (int j = 0; j < NR; j++) if (j != i && cm[j] && w[j] == w[i]) kill = 1'b1;
        m_held[i] = !kill;
        m_word[i] = w[i];
      end else if (v[i] && k[i] == K_SC) begin
        m_held[i] = 1'b0;
      end else begin
        hit = 1'b0;
        for (int j = 0; j < NR; j++) if (cm[j] && w[j] == m_word[i]) hit = 1'b1;
        if (hit) m_held[i] = 1'b0;
      end
    end
  endtask

  task automatic idle();
    cycle(0, K_LD, 0, 0, K_LD, 0);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog R5 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NR; i++) begin
      m_held[i] = 0; m_word[i] = '0; e_rv[i] = 0; e_ok[i] = 0;
    end
    repeat (4) @(negedge clk);
    chk("R10 rsp_valid in reset", sc_rsp_valid[0] | sc_rsp_valid[1], 1'b0);
    rst_n = 1'b1;

    // R10: no reservation after reset
    cycle(1, K_SC, 32'h100, 0, K_LD, 0);
    chk("R10 sc after reset commit", wr_commit[0], 1'b0);
    idle();
    chk("R10 sc after reset ok", sc_rsp_ok[0], 1'b0);

    // R1: byte offset ignored; R5 status
    cycle(1, K_LL, 32'h100, 0, K_LD, 0);
    cycle(1, K_SC, 32'h103, 0, K_LD, 0);
    chk("R1 sc offset commit", wr_commit[0], 1'b1);
    idle();
    chk("R5 sc ok value", sc_rsp_ok[0], 1'b1);

    // R4: reservation consumed
    cycle(1, K_SC, 32'h100, 0, K_LD, 0);
    chk("R4 second sc commit", wr_commit[0], 1'b0);

    // R6: other requester's store clears; own store clears; other word keeps
    cycle(1, K_LL, 32'h100, 0, K_LD, 0);
    cycle(0, K_LD, 0, 1, K_ST, 32'h102);
    cycle(1, K_SC, 32'h100, 0, K_LD, 0);
    chk("R6 foreign store clears", wr_commit[0], 1'b0);
    cycle(1, K_LL, 32'h100, 0, K_LD, 0);
    cycle(1, K_ST, 32'h100, 0, K_LD, 0);
    cycle(1, K_SC, 32'h100, 0, K_LD, 0);
    chk("R6 own store clears", wr_commit[0], 1'b0);
    cycle(1, K_LL, 32'h100, 0, K_LD, 0);
    cycle(0, K_LD, 0, 1, K_ST, 32'h200);
    cycle(1, K_SC, 32'h100, 0, K_LD, 0);
    chk("R6 other word keeps", wr_commit[0], 1'b1);

    // R7: collisions
    cycle(1, K_LL, 32'h100, 1, K_LL, 32'h100);
    cycle(1, K_SC, 32'h100, 1, K_SC, 32'h101);
    chk("R7 req0 wins", wr_commit[0], 1'b1);
    chk("R7 req1 loses", wr_commit[1], 1'b0);
    cycle(0, K_LD, 0, 1, K_LL, 32'h104);
    cycle(1, K_ST, 32'h104, 1, K_SC, 32'h104);
    chk("R7 lower store beats sc", wr_commit[1], 1'b0);
    cycle(1, K_LL, 32'h104, 0, K_LD, 0);
    cycle(1, K_SC, 32'h104, 1, K_ST, 32'h104);
    chk("R7 sc before higher store", wr_commit[0], 1'b1);
    chk("R2 higher store commits", wr_commit[1], 1'b1);

    // R8: link against same-cycle write
    cycle(1, K_LL, 32'h200, 1, K_ST, 32'h200);
    cycle(1, K_SC, 32'h200, 0, K_LD, 0);
    chk("R8 killed link", wr_commit[0], 1'b0);

    // R9: relink replaces
    cycle(1, K_LL, 32'h100, 0, K_LD, 0);
    cycle(1, K_LL, 32'h200, 0, K_LD, 0);
    cycle(1, K_SC, 32'h100, 0, K_LD, 0);
    chk("R9 old reservation gone", wr_commit[0], 1'b0);

    // R3: mismatching word
    cycle(1, K_LL, 32'h100, 0, K_LD, 0);
    cycle(1, K_SC, 32'h104, 0, K_LD, 0);
    chk("R3 other word fails", wr_commit[0], 1'b0);

    // R2: loads do not disturb
    cycle(0, K_LD, 0, 1, K_LL, 32'h1F0);
    cycle(1, K_LD, 32'h1F0, 0, K_LD, 0);
    chk("R2 load no commit", wr_commit[0], 1'b0);
    cycle(0, K_LD, 0, 1, K_SC, 32'h1F2);
    chk("R2 load left reservation", wr_commit[1], 1'b1);

    // Random mix over a small address pool
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] pool [4];
      pool[0] = 32'h100; pool[1] = 32'h104; pool[2] = 32'h200; pool[3] = 32'h1F0;
      cycle(($urandom % 4) != 0, 2'($urandom), pool[$urandom % 4] + ($urandom % 4),
            ($urandom % 4) != 0, 2'($urandom), pool[$urandom % 4] + ($urandom % 4));
    end
    idle();
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule